// File: doc/BRIEF.md
# Triggered Snapshot Trace Capture

This block is an embedded logic-analyser core. It watches a parallel probe bus from the logic under test. While it is armed, it writes one probe sample into a circular sample store on every clock. A hardware comparator checks each sample against a host-programmed pattern. When the pattern matches, the core keeps capturing for a programmed number of further cycles and then freezes. The store then holds one complete snapshot around the trigger moment, and it stays intact until the host arms the core again.

A host reaches the core through a simple word-addressed register port. Through this port it sets the match mask and pattern, sets the post-trigger length, arms the core and polls its state. It then reads the snapshot back oldest-first. A probe wider than 32 bits is returned as several 32-bit words per sample. The trigger is evaluated on every armed cycle, including the first one after the arm write, so no match is missed between snapshots. Store depth is a power of two, set by a parameter (`ADDR_W = 16` gives 65536 entries).

Top module: `trace_capture`

## Requirements
- R1: After reset the status word (control offset 0, bits [2:0] = {done, triggered, armed}) reads 0, and every window read returns 0.
- R2: Writing a 1 in bit 0 of control offset 0 arms the core in any state. Status then reads 1 (armed only), done is cleared, and the sample count restarts from zero. The arm cycle itself writes no sample, and the first sample stored is the probe value at the next clock edge.
- R3: On each armed cycle before the trigger, the sampled probe is stored, and the trigger fires when (probe & mask) == (pattern & mask). The mask words sit at control offsets 8+w and the pattern words at offsets 16+w; word w covers probe bits [32w+31:32w]. A match on the very first armed sample is caught. Status reads 3 while post-trigger capture runs.
- R4: After the trigger sample, exactly P further samples are stored, where P is the low ADDR_W bits of control offset 1 (also readable there). Then status reads 6 (triggered, done). Writing stops, and the snapshot holds until the next arm. P = 0 finishes on the trigger sample itself.
- R5: The window address is {1, sample index, word select}. Index 0 is the oldest stored sample and later indices are later in time. Once more than 2^ADDR_W samples have been written, index 0 is the sample 2^ADDR_W−1 cycles before the last one.
- R6: Control offset 2 returns the window index of the trigger sample.
- R7: Control offset 3 returns the number of valid samples in the snapshot: the samples written since the arm, capped at 2^ADDR_W.
- R8: Word select w of a window read returns probe bits [32w+31:32w], zero-padded above the probe width.
- R9: Window reads while the core is not done return 0 and leave the snapshot untouched. Repeated reads of a finished snapshot return identical data, and arming again after a readout captures afresh.
- R10: Every read strobe gives exactly one `rd_valid` pulse, one cycle later, with its data. No pulse appears without a read.
- R11: An all-zero mask fires the trigger on the first armed sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| probe | input | PROBE_W | Probe bus sampled each armed cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1+ADDR_W+WSEL_W | Word address: control offset or {1, index, word} |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read strobe |
| rd_data | output | 32 | Read data |

## Verification
A broken write pointer or wrap flag shows at the ports in two ways: the sample count and trigger index are off, and window index 0 no longer holds the expected oldest value. Both are visible on the first readout after done. A state machine stuck or early by one cycle changes the status value read on the exact cycle of the last post-trigger sample. The cycle-precise status polls expose that within one read. A comparator or lane-order fault moves the trigger to a different probe value, which shifts every sample in the readout.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_PRE  = 2'd1,
    CAP_POST = 2'd2,
    CAP_DONE = 2'd3
  } cap_state_e;

  localparam logic [4:0] OFF_CTRL  = 5'd0;
  localparam logic [4:0] OFF_POST  = 5'd1;
  localparam logic [4:0] OFF_TIDX  = 5'd2;
  localparam logic [4:0] OFF_COUNT = 5'd3;
  localparam logic [1:0] GRP_MASK  = 2'b01;
  localparam logic [1:0] GRP_PAT   = 2'b10;

endpackage

// File: rtl/trace_match.sv
module trace_match #(
  parameter int LANES = 2
) (
  input  logic [LANES*32-1:0] sample,
  input  logic [LANES*32-1:0] mask,
  input  logic [LANES*32-1:0] pattern,
  output logic                hit
);
  logic [LANES-1:0] lane_eq;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = ((sample[g*32 +: 32] ^ pattern[g*32 +: 32]) & mask[g*32 +: 32]) == 32'd0;
  end

  assign hit = &lane_eq;
endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int WIDTH  = 64,
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/trace_ctl.sv
module trace_ctl
  import trace_cap_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              hit,
  input  logic [ADDR_W-1:0] post_len,
  output cap_state_e        state,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] trig_ptr,
  output logic              wrapped
);
  cap_state_e        st_q, st_d;
  logic [ADDR_W-1:0] wp_q, wp_d, tp_q, tp_d, left_q, left_d;
  logic              wrap_q, wrap_d;

  always_comb begin
    st_d   = st_q;
    wp_d   = wp_q;
    tp_d   = tp_q;
    left_d = left_q;
    wrap_d = wrap_q;
    wr_en  = 1'b0;
    if (arm) begin
      st_d   = CAP_PRE;
      wp_d   = '0;
      wrap_d = 1'b0;
    end else begin
      case (st_q)
        CAP_PRE: begin
          wr_en = 1'b1;
          wp_d  = wp_q + 1'b1;
          if (&wp_q) wrap_d = 1'b1;
          if (hit) begin
            tp_d   = wp_q;
            left_d = post_len;
            st_d   = (post_len == '0) ? CAP_DONE : CAP_POST;
          end
        end
        CAP_POST: begin
          wr_en  = 1'b1;
          wp_d   = wp_q + 1'b1;
          if (&wp_q) wrap_d = 1'b1;
          left_d = left_q - 1'b1;
          if (left_q == ADDR_W'(1)) st_d = CAP_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CAP_IDLE;
      wp_q   <= '0;
      tp_q   <= '0;
      left_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wp_q   <= wp_d;
      tp_q   <= tp_d;
      left_q <= left_d;
      wrap_q <= wrap_d;
    end
  end

  assign state    = st_q;
  assign wr_ptr   = wp_q;
  assign trig_ptr = tp_q;
  assign wrapped  = wrap_q;
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_cap_pkg::*;
#(
  parameter int  PROBE_W = 64,
  parameter int  ADDR_W  = 10,
  localparam int NW      = (PROBE_W + 31) / 32,
  localparam int WSEL_W  = (NW > 1) ? $clog2(NW) : 1,
  localparam int RA_W    = 1 + ADDR_W + WSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probe,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic               rd_valid,
  output logic [31:0]        rd_data
);
  localparam int PADW  = NW * 32;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PADW-1:0] LIVE = {PADW{1'b1}} >> (PADW - PROBE_W);

  // reset release synchroniser
  logic [1:0] rst_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ok = rst_q[1];

  // address decode
  logic              is_win;
  logic [4:0]        off;
  logic [ADDR_W-1:0] win_idx;
  logic [WSEL_W-1:0] win_word;
  logic              arm_req, post_we, mask_we, pat_we;

  assign is_win   = reg_addr[RA_W-1];
  assign off      = reg_addr[4:0];
  assign win_idx  = reg_addr[RA_W-2 -: ADDR_W];
  assign win_word = reg_addr[WSEL_W-1:0];
  assign arm_req  = reg_wr && !is_win && (off == OFF_CTRL) && reg_wdata[0];
  assign post_we  = reg_wr && !is_win && (off == OFF_POST);
  assign mask_we  = reg_wr && !is_win && (off[4:3] == GRP_MASK);
  assign pat_we   = reg_wr && !is_win && (off[4:3] == GRP_PAT);

  // configuration registers
  logic [PADW-1:0]   mask_q, mask_d, pat_q, pat_d;
  logic [ADDR_W-1:0] post_q, post_d;

  always_comb begin
    mask_d = mask_q;
    pat_d  = pat_q;
    post_d = post_q;
    if (post_we) post_d = reg_wdata[ADDR_W-1:0];
    for (int w = 0; w < NW; w++) begin
      if (mask_we && off[2:0] == 3'(w)) mask_d[w*32 +: 32] = reg_wdata & LIVE[w*32 +: 32];
      if (pat_we  && off[2:0] == 3'(w)) pat_d[w*32 +: 32]  = reg_wdata & LIVE[w*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      mask_q <= '0;
      pat_q  <= '0;
      post_q <= '0;
    end else begin
      mask_q <= mask_d;
      pat_q  <= pat_d;
      post_q <= post_d;
    end
  end

  // trigger comparator
  logic [PADW-1:0] probe_pad;
  logic            hit;
  always_comb begin
    probe_pad = '0;
    probe_pad[PROBE_W-1:0] = probe;
  end

  trace_match #(.LANES(NW)) u_match (
    .sample  (probe_pad),
    .mask    (mask_q),
    .pattern (pat_q),
    .hit     (hit)
  );

  // capture sequencing
  cap_state_e        cap_state;
  logic              wr_en, wrapped;
  logic [ADDR_W-1:0] wr_ptr, trig_ptr;

  trace_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_ok),
    .arm      (arm_req),
    .hit      (hit),
    .post_len (post_q),
    .state    (cap_state),
    .wr_en    (wr_en),
    .wr_ptr   (wr_ptr),
    .trig_ptr (trig_ptr),
    .wrapped  (wrapped)
  );

  // chronological window mapping
  logic              done;
  logic [ADDR_W-1:0] base, trig_idx, rd_ptr;
  logic [ADDR_W:0]   sample_cnt;
  logic              win_re;

  assign done       = (cap_state == CAP_DONE);
  assign base       = wrapped ? wr_ptr : '0;
  assign trig_idx   = trig_ptr - base;
  assign sample_cnt = wrapped ? (ADDR_W+1)'(DEPTH) : {1'b0, wr_ptr};
  assign rd_ptr     = base + win_idx;
  assign win_re     = reg_rd && is_win && done;

  logic [PROBE_W-1:0] store_q;

  trace_store #(.WIDTH(PROBE_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata (probe),
    .re    (win_re),
    .raddr (rd_ptr),
    .rdata (store_q)
  );

  // control read mux
  logic [31:0] ctrl_val;
  always_comb begin
    ctrl_val = '0;
    case (off)
      OFF_CTRL:  ctrl_val = {29'd0, done,
                            (cap_state == CAP_POST) || done,
                            (cap_state == CAP_PRE) || (cap_state == CAP_POST)};
      OFF_POST:  ctrl_val = 32'(post_q);
      OFF_TIDX:  ctrl_val = 32'(trig_idx);
      OFF_COUNT: ctrl_val = 32'(sample_cnt);
      default: begin
        for (int w = 0; w < NW; w++) begin
          if (off == {GRP_MASK, 3'(w)}) ctrl_val = mask_q[w*32 +: 32];
          if (off == {GRP_PAT, 3'(w)})  ctrl_val = pat_q[w*32 +: 32];
        end
      end
    endcase
  end

  // read return registers
  logic              rv_q, rv_d, rwin_q, rwin_d;
  logic [31:0]       rctl_q, rctl_d;
  logic [WSEL_W-1:0] rsel_q, rsel_d;

  always_comb begin
    rv_d   = reg_rd;
    rwin_d = rwin_q;
    rctl_d = rctl_q;
    rsel_d = rsel_q;
    if (reg_rd) begin
      rwin_d = win_re;
      rctl_d = is_win ? 32'd0 : ctrl_val;
      rsel_d = win_word;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      rv_q   <= 1'b0;
      rwin_q <= 1'b0;
      rctl_q <= '0;
      rsel_q <= '0;
    end else begin
      rv_q   <= rv_d;
      rwin_q <= rwin_d;
      rctl_q <= rctl_d;
      rsel_q <= rsel_d;
    end
  end

  logic [PADW-1:0] sample_pad;
  logic [31:0]     win_word_val;
  always_comb begin
    sample_pad = '0;
    sample_pad[PROBE_W-1:0] = store_q;
    win_word_val = '0;
    for (int w = 0; w < NW; w++) begin
      if (rsel_q == WSEL_W'(w)) win_word_val = sample_pad[w*32 +: 32];
    end
  end

  assign rd_valid = rv_q;
  assign rd_data  = rwin_q ? win_word_val : rctl_q;
endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk
  import trace_cap_pkg::*;
#(
  parameter int RA_W   = 12,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [RA_W-1:0]   reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input cap_state_e        state,
  input logic [ADDR_W-1:0] wr_ptr
);
  logic arm_seen;
  assign arm_seen = reg_wr && !reg_addr[RA_W-1] && (reg_addr[4:0] == 5'd0) && reg_wdata[0];

  p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    reg_rd |=> rd_valid);

  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    !reg_rd |=> !rd_valid);

  p_win_blocked_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_rd && reg_addr[RA_W-1] && state != CAP_DONE) |=> (rd_data == 32'd0));

  p_arm_restart_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    arm_seen |=> (state == CAP_PRE && wr_ptr == '0));

  p_done_frozen_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (state == CAP_DONE && !arm_seen) |=> (state == CAP_DONE && $stable(wr_ptr)));

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    ((state == CAP_PRE || state == CAP_POST) && !arm_seen) |=>
      (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1)));
endmodule

bind trace_capture trace_capture_chk #(.RA_W(RA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .state     (cap_state),
  .wr_ptr    (wr_ptr)
);

// File: tb/trace_capture_test.sv
module trace_capture_test;
  localparam int PW  = 40;
  localparam int AWD = 4;
  localparam int RAW = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [31:0]     ticks = 32'd0;
  logic [PW-1:0]   probe;
  logic            reg_wr, reg_rd;
  logic [RAW-1:0]  reg_addr;
  logic [31:0]     reg_wdata;
  logic            rd_valid;
  logic [31:0]     rd_data;

  always #10 clk = ~clk;
  always @(posedge clk) ticks <= ticks + 32'd1;
  assign probe = {ticks[7:0] ^ 8'hA5, ticks};

  trace_capture #(.PROBE_W(PW), .ADDR_W(AWD)) uut (
    .clk(clk), .rst_n(rst_n), .probe(probe),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  bit          ended = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // monitor: pops the scoreboard whenever the design returns read data
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10: unrequested read data actual=%h expected=no data", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s: actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  function automatic logic [RAW-1:0] ca(input int o);
    return {1'b0, 5'(o)};
  endfunction

  function automatic logic [RAW-1:0] wa(input int idx, input int w);
    return {1'b1, 4'(idx), 1'(w)};
  endfunction

  function automatic logic [31:0] hi_word(input logic [31:0] v);
    return {24'd0, v[7:0] ^ 8'hA5};
  endfunction

  task automatic wr(input logic [RAW-1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [RAW-1:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_tick(input logic [31:0] t);
    while (ticks != t) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      if (exp_q.size() != 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R10: %0d reads without data actual=%0d expected=0", exp_q.size(), exp_q.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] s, k, t, x;
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(ca(0), 32'd0, "R1 status after reset");
    rd(wa(0, 0), 32'd0, "R1 window after reset");

    // Scenario A: wrapped snapshot, full low-word match, post 5
    t = ticks + 32'd60;
    wr(ca(8), 32'hFFFF_FFFF);
    wr(ca(9), 32'd0);
    wr(ca(16), t);
    wr(ca(17), 32'd0);
    wr(ca(1), 32'd5);
    wr(ca(0), 32'd1);
    rd(ca(1), 32'd5, "R4 post readback");
    rd(ca(8), 32'hFFFF_FFFF, "R3 mask readback");
    wait_tick(t + 32'd5);
    rd(ca(0), 32'd3, "R4 status on last post sample");
    rd(ca(0), 32'd6, "R4 status after post samples");
    rd(ca(3), 32'd16, "R7 count capped at depth");
    rd(ca(2), 32'd10, "R6 trigger index wrapped");
    for (int i = 0; i < 16; i++) begin
      rd(wa(i, 0), t - 32'd10 + 32'(i), "R5 wrapped order low word");
      rd(wa(i, 1), hi_word(t - 32'd10 + 32'(i)), "R8 upper word");
    end
    rd(wa(10, 0), t, "R9 reread trigger sample");
    rd(wa(10, 0), t, "R9 second reread");

    // Scenario D: armed with unreachable trigger, window blocked
    wr(ca(16), 32'd0);
    wr(ca(0), 32'd1);
    repeat (5) @(negedge clk);
    rd(ca(0), 32'd1, "R2 armed status");
    rd(wa(3, 0), 32'd0, "R9 window blocked while armed");

    // Scenario C: re-arm while armed, upper-byte trigger, post 0, unwrapped
    s = ticks;
    k = s + 32'd4;
    x = k + 32'd10;
    wr(ca(8), 32'd0);
    wr(ca(9), 32'h0000_00FF);
    wr(ca(17), hi_word(x));
    wr(ca(1), 32'd0);
    wr(ca(0), 32'd1);
    wait_tick(k + 32'd10);
    rd(ca(0), 32'd1, "R3 status before upper-lane match");
    rd(ca(0), 32'd6, "R4 done on trigger with post 0");
    rd(ca(3), 32'd10, "R7 count after re-arm R2");
    rd(ca(2), 32'd9, "R6 trigger index unwrapped");
    for (int i = 0; i < 10; i++) begin
      rd(wa(i, 0), k + 32'd1 + 32'(i), "R5 unwrapped order");
    end
    rd(wa(9, 1), hi_word(x), "R8 upper word of trigger sample");

    // Scenario B: all-zero mask fires on the first armed sample
    wr(ca(9), 32'd0);
    wr(ca(1), 32'd3);
    k = ticks;
    wr(ca(0), 32'd1);
    rd(ca(0), 32'd1, "R2 status on first armed cycle");
    rd(ca(0), 32'd3, "R11 immediate trigger status");
    wait_tick(k + 32'd4);
    rd(ca(0), 32'd3, "R4 status on last post sample");
    rd(ca(0), 32'd6, "R4 status done");
    rd(ca(3), 32'd4, "R7 count immediate");
    rd(ca(2), 32'd0, "R11 trigger index zero");
    for (int i = 0; i < 4; i++) begin
      rd(wa(i, 0), k + 32'd1 + 32'(i), "R11 samples after immediate trigger");
    end
    rd(wa(0, 0), k + 32'd1, "R9 reread after re-arm");
    rd(wa(0, 1), hi_word(k + 32'd1), "R9 reread upper word");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule